// File: doc/BRIEF.md
# Shadow RAM Segment Attribute Controller

This block is an indexed configuration register file on an 8-bit I/O bus. Software first writes a register number to an index port, then reads or writes that register through a data port. Three of the registers are decoded into memory attributes for the upper BIOS area, C0000h to FFFFFh. That area is split into twelve 16 KB segments from C0000h to EFFFFh, plus one 64 KB block at F0000h. Each of these 13 slots gets a read-source code and a write-target code, which a DRAM controller and bus bridge elsewhere in the chip use to route upper-memory cycles.

Shadowing a 16 KB segment needs two things: its own enable bit, and the master enable of its 64 KB region. Each region also has a write-protect bit. The F0000h block follows a fixed two-state scheme chosen by a single bit. A write to the timing register raises a one-cycle pulse, so the wait-state logic can reload. A combinational lookup port maps any 20-bit memory address to the codes in effect there.

The I/O bus is a plain strobe interface. Every access completes in the cycle in which it is presented. There is no back-pressure: the block never stalls a write or a read, and no stream handshake exists at its edge.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: A write with `io_addr` = 22h loads `io_wdata` into the 8-bit index register, which selects the register targeted by the data port.
- R2: A write with `io_addr` = 24h stores `io_wdata` into the register selected by the index. A read with `io_addr` = 24h returns that register combinationally on `io_rdata`.
- R3: `io_rdata` is FFh whenever the cycle is not a read of address 24h, including reads of 22h or of any other address.
- R4: After reset, register 10h holds 3Fh, register 11h holds F0h and every other register holds 00h. The attribute outputs show the decode of those values: the F0000h block reads external and writes internal, and all twelve segments are external for both reads and writes.
- R5: The read code is 00 for external and 01 for internal. The write code is 00 for external, 01 for internal and 10 for disabled. Slot k (k = 0..11) covers C0000h + k·4000h and sits at bits [2k+1:2k] of `seg_rd_sel` and `seg_wr_sel`. Slot 12 is the F0000h block: when bit 7 of register 11h is 0 it reads internal with writes disabled; when the bit is 1 it reads external and writes internal.
- R6: C-region segment n (slots 0..3) is shadowed when bit n+4 of register 13h and bit 4 of register 11h are both 1. It then reads internal and writes internal, or writes disabled when bit 0 of register 11h is 1.
- R7: D-region segment n (slots 4..7) is shadowed when bit n of register 12h and bit 5 of register 11h are both 1. Its write-protect is bit 1 of register 11h.
- R8: E-region segment n (slots 8..11) is shadowed when bit n+4 of register 12h and bit 6 of register 11h are both 1. Its write-protect is bit 2 of register 11h.
- R9: A segment that is not shadowed has read code 00 and write code 00.
- R10: Attribute outputs change only on the clock edge that completes a data-port write to registers 10h–13h, and then already show the newly written value. A data-port write to any other register leaves them unchanged.
- R11: `wait_upd` is high for exactly the one cycle after each data-port write to register 10h, and low otherwise. `wait_cfg` always shows the stored content of register 10h.
- R12: `lookup_rd`/`lookup_wr` give the codes of the slot containing `lookup_addr`. Addresses below C0000h return 00/00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| wait_cfg | output | 8 | Content of timing register 10h |
| wait_upd | output | 1 | One-cycle pulse after a write to register 10h |
| seg_rd_sel | output | 26 | Read code per slot, 2 bits each, slot 12 = F0000h block |
| seg_wr_sel | output | 26 | Write code per slot, 2 bits each |
| lookup_addr | input | 20 | Memory address to look up |
| lookup_rd | output | 2 | Read code in effect at `lookup_addr` |
| lookup_wr | output | 2 | Write code in effect at `lookup_addr` |

## Verification
The decode is exercised with patterns that isolate one control at a time. Per-segment bits are set while the master enables are on, and then the masters are turned off with all segment bits still set. This separates the AND of the two enables from either input alone. Write-protect is toggled for each region on its own, so a swapped protect bit shows up as a wrong write code in a neighbouring region. A pseudo-random sweep of registers 11h–13h, together with lookups at addresses inside every region, catches slot-ordering and bit-position errors. Writes to unrelated registers and to register 10h confirm that the attributes hold and that the pulse fires only for the timing register.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

  // Slot layout: twelve 16 KB segments, then the 64 KB top block
  localparam int SEGS_PER_REGION = 4;
  localparam int NUM_REGIONS     = 3;
  localparam int NUM_SEGS        = SEGS_PER_REGION * NUM_REGIONS;
  localparam int NUM_SLOTS       = NUM_SEGS + 1;
  localparam int TOP_SLOT        = NUM_SEGS;
  localparam int CODE_W          = 2;
  localparam int VEC_W           = NUM_SLOTS * CODE_W;

  // Register numbers that the decode depends on
  localparam logic [7:0] REG_TIMING = 8'h10;
  localparam logic [7:0] REG_SHCTL  = 8'h11;
  localparam logic [7:0] REG_SHDE   = 8'h12;
  localparam logic [7:0] REG_SHC    = 8'h13;

  // Read-source codes
  localparam logic [1:0] RD_EXT = 2'b00;
  localparam logic [1:0] RD_INT = 2'b01;
  // Write-target codes
  localparam logic [1:0] WR_EXT = 2'b00;
  localparam logic [1:0] WR_INT = 2'b01;
  localparam logic [1:0] WR_DIS = 2'b10;

  function automatic logic [7:0] reg_reset_value(input int idx);
    if (idx == int'(REG_TIMING)) return 8'h3F;
    if (idx == int'(REG_SHCTL))  return 8'hF0;
    return 8'h00;
  endfunction

  // Returns {read_code, write_code} for slot k
  function automatic logic [3:0] slot_attr(input int k, input logic [7:0] ctl,
                                           input logic [7:0] de, input logic [7:0] cseg);
    logic on;
    logic wp;
    int   n;
    n = k % SEGS_PER_REGION;
    if (k == TOP_SLOT)
      return ctl[7] ? {RD_EXT, WR_INT} : {RD_INT, WR_DIS};
    case (k / SEGS_PER_REGION)
      0:       begin on = cseg[n + 4] & ctl[4]; wp = ctl[0]; end
      1:       begin on = de[n]       & ctl[5]; wp = ctl[1]; end
      default: begin on = de[n + 4]   & ctl[6]; wp = ctl[2]; end
    endcase
    if (!on) return {RD_EXT, WR_EXT};
    return {RD_INT, (wp ? WR_DIS : WR_INT)};
  endfunction

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode #(
  parameter int          IO_AW     = 16,
  parameter int          IDX_W     = 8,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic             data_wr,
  output logic             data_rd
);

  logic hit_idx;
  logic hit_data;

  assign hit_idx  = (io_addr == IDX_PORT[IO_AW-1:0]);
  assign hit_data = (io_addr == DATA_PORT[IO_AW-1:0]);
  assign data_wr  = io_wr & hit_data;
  assign data_rd  = io_rd & hit_data;

  always_ff @(posedge clk) begin
    if (!rst_n)              idx_q <= '0;
    else if (io_wr & hit_idx) idx_q <= io_wdata[IDX_W-1:0];
  end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import shadow_attr_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int NUM_REGS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [7:0]       timing_q,
  output logic [7:0]       ctl_nx,
  output logic [7:0]       de_nx,
  output logic [7:0]       cseg_nx
);

  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= reg_reset_value(g);
      else if (wr_en && (idx == IDX_W'(g)))
        regs[g] <= wr_data;
    end
  end

  assign rd_data  = regs[idx];
  assign timing_q = regs[REG_TIMING[IDX_W-1:0]];

  // Values the decode registers see on the edge that completes a write
  assign ctl_nx  = (wr_en && idx == REG_SHCTL[IDX_W-1:0]) ? wr_data : regs[REG_SHCTL[IDX_W-1:0]];
  assign de_nx   = (wr_en && idx == REG_SHDE[IDX_W-1:0])  ? wr_data : regs[REG_SHDE[IDX_W-1:0]];
  assign cseg_nx = (wr_en && idx == REG_SHC[IDX_W-1:0])   ? wr_data : regs[REG_SHC[IDX_W-1:0]];

endmodule

// File: rtl/seg_attr_decode.sv
module seg_attr_decode
  import shadow_attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [7:0]       ctl,
  input  logic [7:0]       de,
  input  logic [7:0]       cseg,
  output logic [VEC_W-1:0] rd_vec,
  output logic [VEC_W-1:0] wr_vec
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [3:0] RST_ATTR = slot_attr(k, reg_reset_value(int'(REG_SHCTL)),
                                                reg_reset_value(int'(REG_SHDE)),
                                                reg_reset_value(int'(REG_SHC)));
    logic [3:0] nx;
    assign nx = slot_attr(k, ctl, de, cseg);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_vec[CODE_W*k +: CODE_W] <= RST_ATTR[3:2];
        wr_vec[CODE_W*k +: CODE_W] <= RST_ATTR[1:0];
      end else if (update) begin
        rd_vec[CODE_W*k +: CODE_W] <= nx[3:2];
        wr_vec[CODE_W*k +: CODE_W] <= nx[1:0];
      end
    end
  end

endmodule

// File: rtl/attr_lookup.sv
module attr_lookup
  import shadow_attr_pkg::*;
(
  input  logic [19:0]      mem_addr,
  input  logic [VEC_W-1:0] rd_vec,
  input  logic [VEC_W-1:0] wr_vec,
  output logic [1:0]       lk_rd,
  output logic [1:0]       lk_wr
);

  logic       upper;
  logic [3:0] slot;

  always_comb begin
    upper = (mem_addr[19:18] == 2'b11);
    if (mem_addr[17:16] == 2'b11) slot = 4'(TOP_SLOT);
    else                          slot = mem_addr[17:14];
    if (upper) begin
      lk_rd = rd_vec[CODE_W*slot +: CODE_W];
      lk_wr = wr_vec[CODE_W*slot +: CODE_W];
    end else begin
      lk_rd = RD_EXT;
      lk_wr = WR_EXT;
    end
  end

endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
  import shadow_attr_pkg::*;
#(
  parameter int          IO_AW     = 16,
  parameter int          IDX_W     = 8,
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic [7:0]       wait_cfg,
  output logic             wait_upd,
  output logic [25:0]      seg_rd_sel,
  output logic [25:0]      seg_wr_sel,
  input  logic [19:0]      lookup_addr,
  output logic [1:0]       lookup_rd,
  output logic [1:0]       lookup_wr
);

  logic [IDX_W-1:0] idx_q;
  logic             data_wr;
  logic             data_rd;
  logic [7:0]       reg_rdata;
  logic [7:0]       ctl_nx, de_nx, cseg_nx;
  logic             hits_decode;

  io_port_decode #(
    .IO_AW(IO_AW), .IDX_W(IDX_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
  ) u_io (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .idx_q(idx_q), .data_wr(data_wr), .data_rd(data_rd)
  );

  cfg_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .idx(idx_q), .wr_data(io_wdata),
    .rd_data(reg_rdata), .timing_q(wait_cfg), .ctl_nx(ctl_nx), .de_nx(de_nx),
    .cseg_nx(cseg_nx)
  );

  // Recompute only for the timing register and the three shadow registers
  assign hits_decode = data_wr && (idx_q >= REG_TIMING[IDX_W-1:0]) &&
                       (idx_q <= REG_SHC[IDX_W-1:0]);

  seg_attr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .update(hits_decode), .ctl(ctl_nx), .de(de_nx),
    .cseg(cseg_nx), .rd_vec(seg_rd_sel), .wr_vec(seg_wr_sel)
  );

  attr_lookup u_lk (
    .mem_addr(lookup_addr), .rd_vec(seg_rd_sel), .wr_vec(seg_wr_sel),
    .lk_rd(lookup_rd), .lk_wr(lookup_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wait_upd <= 1'b0;
    else        wait_upd <= data_wr && (idx_q == REG_TIMING[IDX_W-1:0]);
  end

  assign io_rdata = data_rd ? reg_rdata : 8'hFF;

endmodule

// File: rtl/shadow_attr_ctrl_chk.sv
module shadow_attr_ctrl_chk
  import shadow_attr_pkg::*;
#(
  parameter int          IO_AW     = 16,
  parameter int          IDX_W     = 8,
  parameter logic [15:0] DATA_PORT = 16'h0024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_wr,
  input logic             io_rd,
  input logic [IO_AW-1:0] io_addr,
  input logic [7:0]       io_rdata,
  input logic [IDX_W-1:0] idx_q,
  input logic             wait_upd,
  input logic [25:0]      seg_rd_sel,
  input logic [25:0]      seg_wr_sel
);

  logic dwr;
  assign dwr = io_wr && (io_addr == DATA_PORT[IO_AW-1:0]);

  // R3: anything but a data-port read returns all ones
  p_other_read_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_addr == DATA_PORT[IO_AW-1:0]) |-> io_rdata == 8'hFF);

  // R10: attributes only move after a write to 10h..13h
  p_attr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({seg_rd_sel, seg_wr_sel}) |->
      $past(dwr && idx_q >= REG_TIMING[IDX_W-1:0] && idx_q <= REG_SHC[IDX_W-1:0]));

  // R11: pulse follows a timing-register write, and only that
  p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wait_upd |-> $past(dwr && idx_q == REG_TIMING[IDX_W-1:0]));
  p_pulse_fires_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == REG_TIMING[IDX_W-1:0]) |=> wait_upd);

  // R5: top block is either internal/disabled or external/internal
  p_top_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_rd_sel[2*TOP_SLOT +: 2] == RD_INT) == (seg_wr_sel[2*TOP_SLOT +: 2] == WR_DIS));

  for (genvar k = 0; k < NUM_SEGS; k++) begin : g_seg
    // R9: an external read implies an external write for 16 KB segments
    p_unshadowed_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seg_rd_sel[2*k +: 2] == RD_EXT |-> seg_wr_sel[2*k +: 2] == WR_EXT);
    // R5: codes stay inside the legal sets
    p_legal_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seg_rd_sel[2*k+1] == 1'b0 && seg_wr_sel[2*k +: 2] != 2'b11);
  end

endmodule

bind shadow_attr_ctrl shadow_attr_ctrl_chk #(
  .IO_AW(IO_AW), .IDX_W(IDX_W), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_rdata(io_rdata), .idx_q(idx_q), .wait_upd(wait_upd),
  .seg_rd_sel(seg_rd_sel), .seg_wr_sel(seg_wr_sel)
);

// File: tb/test_shadow_attr_ctrl.sv
module test_shadow_attr_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata, wait_cfg;
  logic        wait_upd;
  logic [25:0] seg_rd_sel, seg_wr_sel;
  logic [19:0] lookup_addr = 20'h0;
  logic [1:0]  lookup_rd, lookup_wr;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc++;

  shadow_attr_ctrl i_shadow_attr_ctrl (.*);

  // Bench-side register model
  logic [7:0] m_regs [256];
  logic [7:0] m_idx;

  typedef struct packed {
    int          due;
    logic [25:0] rd;
    logic [25:0] wr;
    logic        pulse;
    logic [7:0]  wcfg;
  } item_t;
  item_t exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected {rd,wr} for slot k from the requirement text
  function automatic logic [3:0] exp_slot(input int k);
    logic [7:0] c11, c12, c13;
    logic en, prot;
    c11 = m_regs[8'h11]; c12 = m_regs[8'h12]; c13 = m_regs[8'h13];
    if (k == 12) return c11[7] ? 4'b0001 : 4'b0110;        // R5
    if (k < 4)      begin en = c13[k+4] && c11[4]; prot = c11[0]; end  // R6
    else if (k < 8) begin en = c12[k-4] && c11[5]; prot = c11[1]; end  // R7
    else            begin en = c12[k-4] && c11[6]; prot = c11[2]; end  // R8 (bit k-8+4)
    if (!en) return 4'b0000;                                 // R9
    return prot ? 4'b0110 : 4'b0101;
  endfunction

  function automatic item_t model_item(input int due, input logic pulse);
    item_t it;
    it.due = due; it.pulse = pulse; it.wcfg = m_regs[8'h10];
    for (int k = 0; k < 13; k++) begin
      logic [3:0] a;
      a = exp_slot(k);
      it.rd[2*k +: 2] = a[3:2];
      it.wr[2*k +: 2] = a[1:0];
    end
    return it;
  endfunction

  // Driver: one I/O write, expectations pushed to the scoreboard
  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    if (a == 16'h0022) m_idx = d;
    else if (a == 16'h0024) begin
      m_regs[m_idx] = d;
      exp_q.push_back(model_item(cyc + 1, m_idx == 8'h10));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] r, input logic [7:0] d, input string tag);
    io_write(16'h0022, r, tag);
    io_write(16'h0024, d, tag);
  endtask

  task automatic io_read_check(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1;
    check(io_rdata == exp, tag, io_rdata, exp);
    io_rd = 1'b0;
  endtask

  task automatic lookup_check(input logic [19:0] a, input string tag);
    logic [3:0] e;
    int k;
    @(negedge clk);
    lookup_addr = a;
    #1;
    if (a[19:18] != 2'b11) e = 4'b0000;
    else begin
      k = (a[17:16] == 2'b11) ? 12 : int'(a[17:14]);
      e = exp_slot(k);
    end
    check({lookup_rd, lookup_wr} == e, tag, {lookup_rd, lookup_wr}, e);
  endtask

  // Monitor: compare scoreboard items in their due cycle
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        item_t it;
        string t;
        it = exp_q.pop_front();
        t  = tag_q.pop_front();
        check(seg_rd_sel == it.rd, {t, " rd_sel"}, 32'(seg_rd_sel), 32'(it.rd));
        check(seg_wr_sel == it.wr, {t, " wr_sel"}, 32'(seg_wr_sel), 32'(it.wr));
        check(wait_upd == it.pulse, {t, " R11 pulse"}, 32'(wait_upd), 32'(it.pulse));
        check(wait_cfg == it.wcfg, {t, " R11 wait_cfg"}, 32'(wait_cfg), 32'(it.wcfg));
      end
    end
  end

  task automatic finish_bench();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_bench();
  end

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
    m_regs[8'h10] = 8'h3F; m_regs[8'h11] = 8'hF0; m_idx = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state of the attributes and registers
    exp_q.push_back(model_item(cyc, 1'b0)); tag_q.push_back("R4 reset attrs");
    @(negedge clk);
    io_write(16'h0022, 8'h10, "R1 index");
    io_read_check(16'h0024, 8'h3F, "R4 reg10 reset");
    io_write(16'h0022, 8'h11, "R1 index");
    io_read_check(16'h0024, 8'hF0, "R4 reg11 reset");
    io_write(16'h0022, 8'h13, "R1 index");
    io_read_check(16'h0024, 8'h00, "R4 reg13 reset");

    // R3: other addresses and no-read cycles give FFh
    io_read_check(16'h0022, 8'hFF, "R3 read index port");
    io_read_check(16'h0023, 8'hFF, "R3 read 23h");
    io_read_check(16'h0124, 8'hFF, "R3 read aliasing addr");

    // R1/R2/R10: unrelated register write, read-back, no attribute change
    wr_reg(8'h40, 8'hA5, "R10 unrelated write");
    io_read_check(16'h0024, 8'hA5, "R2 readback 40h");
    wr_reg(8'h14, 8'h5A, "R10 write 14h");
    io_write(16'h0022, 8'h40, "R1 reindex");
    io_read_check(16'h0024, 8'hA5, "R1 index reselect");

    // R5: top block inverted bit
    wr_reg(8'h11, 8'h70, "R5 top internal");
    lookup_check(20'hF1234, "R12 R5 lookup top");
    wr_reg(8'h11, 8'hF0, "R5 top external");
    lookup_check(20'hFFFFF, "R12 R5 lookup top end");

    // R6: C region shadow then write-protect
    wr_reg(8'h13, 8'hF0, "R6 C all on");
    lookup_check(20'hC4000, "R12 R6 lookup C1");
    wr_reg(8'h11, 8'hF1, "R6 C protect");
    lookup_check(20'hCC000, "R12 R6 lookup C3");
    wr_reg(8'h13, 8'h50, "R6 C seg0 seg2");

    // R7: D region
    wr_reg(8'h12, 8'h05, "R7 D seg0 seg2");
    lookup_check(20'hD8000, "R12 R7 lookup D2");
    lookup_check(20'hD4000, "R12 R7 lookup D1 off");
    wr_reg(8'h11, 8'hF2, "R7 D protect");

    // R8: E region
    wr_reg(8'h12, 8'hA0, "R8 E seg1 seg3");
    lookup_check(20'hE4000, "R12 R8 lookup E1");
    wr_reg(8'h11, 8'hF4, "R8 E protect");
    lookup_check(20'hEC000, "R12 R8 lookup E3");

    // R9: masters off with every segment bit set
    wr_reg(8'h12, 8'hFF, "R9 all seg bits");
    wr_reg(8'h13, 8'hFF, "R9 all seg bits");
    wr_reg(8'h11, 8'h87, "R9 masters off");
    lookup_check(20'hD0000, "R12 R9 lookup D0");

    // R11: timing register pulse and value
    wr_reg(8'h10, 8'h12, "R11 timing write");
    io_read_check(16'h0024, 8'h12, "R2 readback 10h");
    lookup_check(20'h80000, "R12 below area");

    // Sweep: pseudo-random shadow settings (R6 R7 R8 R12)
    lfsr = 8'hB7;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_reg(8'h11 + 8'(i % 3), lfsr, "R10 sweep");
      lookup_check({2'b11, lfsr[3:0], 14'h0123}, "R12 sweep lookup");
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    finish_bench();
  end

endmodule